// File: doc/BRIEF.md
# Dual-Channel Edge/Level Interrupt Front End

This block takes asynchronous external pin inputs and turns them into interrupt requests. There is one channel per pin. Each channel synchronizes its pin with a flop chain. It then compares the current synchronized sample with the previous one to find a valid waveform: a falling edge, a rising edge, or either edge, as its control word selects. A valid waveform sets a sticky request flag. The CPU can poll that flag with a test-and-skip strobe, which also consumes the flag. The flag can also raise an interrupt when the channel's enable bit is set.

Each channel also drives a key-on wakeup output. That output either follows a chosen pin level or pulses on an edge of the chosen polarity. The same polarity bit serves both the wakeup path and one-sided detection. Channel 0's valid waveform is also given out as a single-cycle start trigger for a timer.

Top module: `ext_irq_front`

## Requirements
- R1: Each channel has its own 4-bit control word, loaded from `ctl_wdata_i` when its bit of `ctl_we_i` is high. Bit 0 is the interrupt enable, bit 1 selects both-edge detection, bit 2 is the polarity and bit 3 is the wakeup mode. Pin activity on one channel never changes another channel's flag.
- R2: With bit 1 = 1, both edges are valid. With bit 1 = 0, a falling edge is valid when bit 2 = 0 and a rising edge is valid when bit 2 = 1.
- R3: A pin change appears on `flag_o` after the third rising clock edge that follows it (two synchronizer stages plus the flag register), and not before.
- R4: Reset clears all flags and all outputs. A flag, once set, stays set until a skip test consumes it.
- R5: `irq_o` of a channel is high exactly when its flag is set and its control bit 0 is 1.
- R6: `skip_o` is high in the same cycle whenever `skip_req_i` is high and the flag is set. The flag then clears at the next clock edge, unless a valid waveform is detected in that same cycle, in which case the flag stays set.
- R7: With bit 3 = 0, `wake_o` is high while the synchronized pin equals bit 2 (low level for 0, high level for 1), with the same latency as the flag. With bit 3 = 1, `wake_o` is a one-cycle pulse on an edge of the bit-2 polarity, whatever bit 1 holds.
- R8: A control write to a channel suppresses detection on that channel in the write cycle, so reconfiguring cannot create a false request.
- R9: `tmr_start_o` is a one-cycle pulse in the cycle in which channel 0's flag is set by a valid waveform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_i | input | NUM_CH | Asynchronous pin inputs |
| ctl_we_i | input | NUM_CH | Per-channel control write strobe |
| ctl_wdata_i | input | 4 | Control word write data |
| skip_req_i | input | NUM_CH | Test-and-skip strobe per channel |
| skip_o | output | NUM_CH | Skip taken (flag was set) |
| flag_o | output | NUM_CH | Request flags |
| irq_o | output | NUM_CH | Enabled interrupt requests |
| wake_o | output | NUM_CH | Key-on wakeup outputs |
| tmr_start_o | output | 1 | Timer count-start pulse from channel 0 |

## Verification
The bench builds the block with its defaults: NUM_CH = 2 and SYNC_STAGES = 2. With these values the three-edge latency can be counted exactly, and every combination of wakeup mode, polarity and both-edge bits can be swept against both pin transitions on both channels. Two channels are enough to check that one channel's edges never reach the other channel's flag. The short synchronizer also makes it easy to place a detection in exactly the cycle of a skip test or of a control write, which exercises the priority and masking cases.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
  localparam int unsigned CTL_W = 4;

  typedef struct packed {
    logic wake_edge;  // bit 3
    logic pol;        // bit 2: 0 falling/low, 1 rising/high
    logic both;       // bit 1
    logic irq_en;     // bit 0
  } ctl_t;
endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/eirq_chan.sv
module eirq_chan
  import eirq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic ctl_we_i,
  input  ctl_t ctl_wdata_i,
  input  logic skip_req_i,
  output logic skip_o,
  output logic flag_o,
  output logic irq_o,
  output logic wake_o,
  output logic det_o
);
  ctl_t ctl_q;
  logic lvl, prev_q, flag_q, wake_q;
  logic rise, fall, pol_edge, det;

  eirq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (lvl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ctl_q <= '0;
    else if (ctl_we_i) ctl_q <= ctl_wdata_i;
  end

  // previous sample tracks every cycle, so a write reloads it as well
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl;
  end

  assign rise     = lvl & ~prev_q;
  assign fall     = ~lvl & prev_q;
  assign pol_edge = ctl_q.pol ? rise : fall;
  assign det      = ~ctl_we_i & (ctl_q.both ? (rise | fall) : pol_edge);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      flag_q <= det | (flag_q & ~skip_req_i);  // new edge wins over skip
      wake_q <= ctl_q.wake_edge ? pol_edge : (lvl == ctl_q.pol);
    end
  end

  assign skip_o = flag_q & skip_req_i;
  assign flag_o = flag_q;
  assign irq_o  = flag_q & ctl_q.irq_en;
  assign wake_o = wake_q;
  assign det_o  = det;

  AST_FLAG_ON_DET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    det |=> flag_q);  // R4
  AST_ROSE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(det));  // R4
  AST_SKIP_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (skip_req_i && flag_q && !det) |=> !flag_q);  // R6
  AST_WR_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_we_i |=> !$rose(flag_q));  // R8
  AST_POL_ONE_SIDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (det && !ctl_q.both) |-> (lvl == ctl_q.pol));  // R2
endmodule

// File: rtl/ext_irq_front.sv
module ext_irq_front
  import eirq_pkg::*;
#(
  parameter int unsigned NUM_CH      = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] pin_i,
  input  logic [NUM_CH-1:0] ctl_we_i,
  input  logic [CTL_W-1:0]  ctl_wdata_i,
  input  logic [NUM_CH-1:0] skip_req_i,
  output logic [NUM_CH-1:0] skip_o,
  output logic [NUM_CH-1:0] flag_o,
  output logic [NUM_CH-1:0] irq_o,
  output logic [NUM_CH-1:0] wake_o,
  output logic              tmr_start_o
);
  localparam int unsigned TMR_CH = 0;

  logic [NUM_CH-1:0] det;
  logic              tmr_q;
  ctl_t              wdata;

  assign wdata = ctl_t'(ctl_wdata_i);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    eirq_chan #(.SYNC_STAGES(SYNC_STAGES)) u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .pin_i      (pin_i[c]),
      .ctl_we_i   (ctl_we_i[c]),
      .ctl_wdata_i(wdata),
      .skip_req_i (skip_req_i[c]),
      .skip_o     (skip_o[c]),
      .flag_o     (flag_o[c]),
      .irq_o      (irq_o[c]),
      .wake_o     (wake_o[c]),
      .det_o      (det[c])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tmr_q <= 1'b0;
    else         tmr_q <= det[TMR_CH];
  end

  assign tmr_start_o = tmr_q;

  AST_TMR_WITH_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_q |-> flag_o[TMR_CH]);  // R9
  AST_TMR_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_q |-> $past(det[TMR_CH]));  // R9
endmodule

// File: tb/ext_irq_front_tb.sv
module ext_irq_front_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NCH = 2;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NCH-1:0] pin = '0, ctl_we = '0, skip_req = '0;
  logic [3:0]     wdata = '0;
  logic [NCH-1:0] skip_o, flag_o, irq_o, wake_o;
  logic           tmr_o;
  int             n_chk = 0, n_bad = 0;
  bit             done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ext_irq_front #(.NUM_CH(NCH), .SYNC_STAGES(2)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .ctl_we_i(ctl_we),
    .ctl_wdata_i(wdata), .skip_req_i(skip_req), .skip_o(skip_o),
    .flag_o(flag_o), .irq_o(irq_o), .wake_o(wake_o), .tmr_start_o(tmr_o)
  );

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(input string req, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic clear_all();
    skip_req = '1; step(); skip_req = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: got hang expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R4 reset state
    chk("R4 rst flag0", flag_o[0], 1'b0); chk("R4 rst flag1", flag_o[1], 1'b0);
    chk("R4 rst irq", |irq_o, 1'b0); chk("R4 rst tmr", tmr_o, 1'b0);
    chk("R4 rst wake", |wake_o, 1'b0); chk("R4 rst skip", |skip_o, 1'b0);
    step(); rst_n = 1'b1; step(); step();

    // sweep: channel x control (wake mode, polarity, both) x transition
    for (int ch = 0; ch < NCH; ch++) begin
      for (int cfg = 0; cfg < 8; cfg++) begin
        for (int dir = 0; dir < 2; dir++) begin
          logic wm, pl, bo, en, st, nw, rs, fl, valid, pe;
          wm = cfg[2]; pl = cfg[1]; bo = cfg[0]; en = cfg[0] ^ dir[0];
          st = ~dir[0]; nw = dir[0];
          rs = nw & ~st; fl = st & ~nw;
          pe = pl ? rs : fl;
          valid = bo ? 1'b1 : pe;
          pin[ch] = st;
          wdata = {wm, pl, bo, en}; ctl_we[ch] = 1'b1; step(); ctl_we = '0;
          repeat (4) step();
          clear_all(); step();
          chk("R6 cleared by skip", flag_o[ch], 1'b0);
          chk("R7 wake before", wake_o[ch], wm ? 1'b0 : (st == pl));
          pin[ch] = nw;
          step(); step();
          chk("R3 no early flag", flag_o[ch], 1'b0);
          step();
          chk("R2 flag", flag_o[ch], valid);
          chk("R5 irq", irq_o[ch], valid & en);
          chk("R7 wake after", wake_o[ch], wm ? pe : (nw == pl));
          chk("R9 tmr pulse", tmr_o, (ch == 0) & valid);
          chk("R1 other flag", flag_o[1-ch], 1'b0);
          step();
          chk("R4 flag held", flag_o[ch], valid);
          chk("R9 tmr one cycle", tmr_o, 1'b0);
          if (wm) chk("R7 wake pulse ends", wake_o[ch], 1'b0);
          clear_all();
        end
      end
    end

    // R6 skip priority with both edges on channel 0
    wdata = 4'b0011; ctl_we[0] = 1'b1; step(); ctl_we = '0;
    pin[0] = ~pin[0]; repeat (3) step();
    chk("R6 set before skip", flag_o[0], 1'b1);
    pin[0] = ~pin[0]; step(); step();
    skip_req[0] = 1'b1; #1;
    chk("R6 skip_o same cycle", skip_o[0], 1'b1);
    step(); skip_req = '0;
    chk("R6 edge beats skip", flag_o[0], 1'b1);
    skip_req[0] = 1'b1; step();
    chk("R6 cleared", flag_o[0], 1'b0);
    chk("R6 no skip when clear", skip_o[0], 1'b0);
    skip_req = '0;

    // R8 write in detection cycle masks it
    pin[0] = ~pin[0]; step(); step();
    ctl_we[0] = 1'b1; step(); ctl_we = '0;
    chk("R8 masked flag", flag_o[0], 1'b0);
    chk("R8 masked tmr", tmr_o, 1'b0);
    step();
    chk("R8 still clear", flag_o[0], 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule